// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block arbitrates up to 32 level-sensitive interrupt request lines for a single core. Each line has an enable bit and a 4-bit urgency value, and a smaller value means more urgent. Software sets a global grouping value that splits every urgency value in two. The upper bits form the preemption level and the remaining low bits form the subpriority. In every cycle the arbiter picks the most urgent line that is both pending and enabled. It then decides whether the core may take that line now: either because nothing is in service, or because the winner may nest on top of the interrupt currently in service.

The core accepts an offered request with `ack_i`. The arbiter then records the urgency of the taken line on an internal nesting stack. When the core finishes a handler it pulses `done_i`, which pops the stack and restores the previous level. Configuration goes through a one-cycle write port with four targets: a write-one-to-set enable word, a write-one-to-clear enable word, a per-line urgency byte, and a keyed control word that carries the grouping value.

Top module: `gpa_ctrl`

## Requirements
- R1: After a synchronous reset, the following all hold, so no line can win even when every line is pending:
  - every enable bit is 0;
  - the grouping value is 0;
  - the nesting depth is 0;
  - `act_prio_o` is 0.
- R2: A write with `wr_sel`=0 sets each enable bit whose position in `wr_data` is a 1. A write with `wr_sel`=1 clears each enable bit whose position in `wr_data` is a 1. Bit n of `wr_data` addresses line n, and zero bits leave the enable bits unchanged.
- R3: A write with `wr_sel`=2 stores `wr_data[7:4]` as the urgency of line `wr_idx`. The other bits of `wr_data` have no effect on the stored urgency.
- R4: A write with `wr_sel`=3 changes the grouping value only when `wr_data[31:16]` equals 16'h05FA. In that case the new grouping value is `wr_data[10:8]`, and a value above 4 is stored as 4. Any other key leaves the grouping value unchanged.
- R5: A line whose enable bit is 0 never wins, even while it is pending. Its pending input stays visible, so enabling it lets it win at once.
- R6: The winner is the pending enabled line with the numerically smallest urgency. Among equal urgencies, the lowest line number wins. This is the same order as comparing preemption level first, then subpriority, then line number.
- R7: When the nesting depth is 0 and a winner exists, `take_o` is 1.
- R8: When the nesting depth is above 0, `take_o` is 1 only if the winner's preemption level is strictly lower than that of the innermost active entry. The preemption level is the urgency shifted right by (4 − grouping value). An equal level waits, and subpriority never causes nesting.
- R9: With grouping value 0, `take_o` stays 0 whenever the nesting depth is above 0.
- R10: `ack_i` pushes the winner's urgency onto the stack when all of the following hold: `take_o` is 1, `done_i` is low, and the stack is not full. After the push, `depth_o` has increased by 1 and `act_prio_o` shows the pushed urgency. In every other case `ack_i` has no effect.
- R11: `done_i` at a depth above 0 pops one entry and restores `act_prio_o` to the previous entry, or to 0 when the stack becomes empty. `done_i` at depth 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 set-enable, 1 clear-enable, 2 urgency, 3 control |
| wr_idx | input | 5 | Line addressed by an urgency write |
| wr_data | input | 32 | Write data |
| pend_i | input | LINES | Pending request per line |
| ack_i | input | 1 | Core takes the offered winner |
| done_i | input | 1 | Core completes the innermost active handler |
| win_vld_o | output | 1 | A pending enabled line exists |
| win_id_o | output | 5 | Line number of the winner |
| take_o | output | 1 | The winner may be taken now |
| depth_o | output | DEPTH_W | Number of nested active entries |
| act_prio_o | output | 4 | Urgency of the innermost active entry, 0 when idle |

## Verification
The bench targets the following corner cases, each paired with the wrong behaviour it would expose:
- **Equal preemption levels with different subpriorities.** A design that compared the full urgency instead of only the preemption field would nest a request that must wait.
- **Grouping value 0.** A wrong shift would let a more urgent request nest although no preemption bits exist.
- **Control writes with a bad key, or with an out-of-range grouping value.** A design that skipped the key check or stored the raw field would change nesting behaviour afterwards.
- **Urgency ties and disabled lines.** Tie-breaking toward the higher line number, or letting disabled lines take part, shows up as a wrong winner.
- **Completion.** Popping to the wrong stack entry leaves a stale level that blocks or admits the wrong nesting.

All five grouping values are swept with random urgencies and pending patterns.

// File: rtl/gpa_pkg.sv
`timescale 1ns/1ps
package gpa_pkg;

    localparam int PRIO_W  = 4;
    localparam int ID_W    = 5;
    localparam int GRP_W   = 3;
    localparam logic [15:0] CTRL_KEY = 16'h05FA;
    localparam logic [GRP_W-1:0] GRP_MAX = 3'd4;

    typedef enum logic [1:0] {
        WR_SET_EN = 2'd0,
        WR_CLR_EN = 2'd1,
        WR_PRIO   = 2'd2,
        WR_CTRL   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // preemption level: the top 'grp' bits of the urgency value
    function automatic logic [PRIO_W-1:0] pre_of(logic [PRIO_W-1:0] p,
                                                 logic [GRP_W-1:0] grp);
        return p >> (GRP_MAX - grp);
    endfunction

    function automatic logic [GRP_W-1:0] grp_sat(logic [GRP_W-1:0] g);
        return (g > GRP_MAX) ? GRP_MAX : g;
    endfunction

    // left operand always carries the lower line numbers, so ties go left
    function automatic cand_t pick(cand_t a, cand_t b);
        if (a.vld && (!b.vld || a.prio <= b.prio))
            return a;
        return b;
    endfunction

endpackage

// File: rtl/gpa_regs.sv
`timescale 1ns/1ps
module gpa_regs
    import gpa_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [ID_W-1:0]               wr_idx,
    input  logic [31:0]                   wr_data,
    output logic [LINES-1:0]              en_o,
    output logic [LINES-1:0][PRIO_W-1:0]  prio_o,
    output logic [GRP_W-1:0]              grp_o
);

    wr_sel_e             sel;
    logic                key_ok;
    logic [LINES-1:0]    mask;
    logic [LINES-1:0]    en_q;
    logic [GRP_W-1:0]    grp_q;

    assign sel    = wr_sel_e'(wr_sel);
    assign key_ok = (wr_data[31:16] == CTRL_KEY);
    assign mask   = wr_data[LINES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            grp_q <= '0;
        end else if (wr_en) begin
            case (sel)
                WR_SET_EN: en_q <= en_q | mask;
                WR_CLR_EN: en_q <= en_q & ~mask;
                WR_CTRL:   if (key_ok) grp_q <= grp_sat(wr_data[10:8]);
                default:   ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_prio
            logic [PRIO_W-1:0] prio_q;
            always_ff @(posedge clk) begin
                if (rst)
                    prio_q <= '0;
                else if (wr_en && sel == WR_PRIO && wr_idx == ID_W'(i))
                    prio_q <= wr_data[7:4];
            end
            assign prio_o[i] = prio_q;
        end
    endgenerate

    assign en_o  = en_q;
    assign grp_o = grp_q;

    // R4
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == WR_CTRL && !key_ok) |=> $stable(grp_o));

    // R2
    set_en_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == WR_SET_EN) |=> ((en_o & $past(mask)) == $past(mask)));

    // R2
    clr_en_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == WR_CLR_EN) |=> ((en_o & $past(mask)) == '0));

endmodule

// File: rtl/gpa_select.sv
`timescale 1ns/1ps
module gpa_select
    import gpa_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LINES-1:0]              pend_i,
    input  logic [LINES-1:0]              en_i,
    input  logic [LINES-1:0][PRIO_W-1:0]  prio_i,
    output cand_t                         win_o
);

    localparam int LVLS = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int PAD  = 1 << LVLS;

    // heap-ordered tree: node k merges nodes 2k and 2k+1, leaves at PAD+i
    cand_t node [2*PAD];

    assign node[0] = '0;

    generate
        for (genvar i = 0; i < PAD; i++) begin : g_leaf
            if (i < LINES) begin : g_real
                assign node[PAD+i] = '{vld:  pend_i[i] & en_i[i],
                                       prio: prio_i[i],
                                       id:   ID_W'(i)};
            end else begin : g_pad
                assign node[PAD+i] = '0;
            end
        end
        for (genvar k = 1; k < PAD; k++) begin : g_node
            assign node[k] = pick(node[2*k], node[2*k+1]);
        end
    endgenerate

    assign win_o = node[1];

    // R5
    win_legal_chk: assert property (@(posedge clk) disable iff (rst)
        win_o.vld |-> (pend_i[win_o.id] && en_i[win_o.id]));

    // R5
    win_exists_chk: assert property (@(posedge clk) disable iff (rst)
        !win_o.vld |-> ((pend_i & en_i) == '0));

endmodule

// File: rtl/gpa_nest.sv
`timescale 1ns/1ps
module gpa_nest
    import gpa_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_vld_i,
    input  logic [PRIO_W-1:0]    win_prio_i,
    input  logic [GRP_W-1:0]     grp_i,
    input  logic                 ack_i,
    input  logic                 done_i,
    output logic                 take_o,
    output logic [DEPTH_W-1:0]   depth_o,
    output logic [PRIO_W-1:0]    act_prio_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PRIO_W-1:0]  stk [DEPTH];
    logic [DEPTH_W-1:0] depth_q;
    logic [IDX_W-1:0]   top_idx;
    logic [IDX_W-1:0]   push_idx;
    logic [PRIO_W-1:0]  top_prio;
    logic               idle;
    logic               full;
    logic               push;
    logic               pop;

    assign idle     = (depth_q == '0);
    assign full     = (depth_q == DEPTH_W'(DEPTH));
    assign top_idx  = IDX_W'(depth_q - 1'b1);
    assign push_idx = IDX_W'(depth_q);
    assign top_prio = idle ? '0 : stk[top_idx];

    assign take_o = win_vld_i &&
                    (idle || (pre_of(win_prio_i, grp_i) < pre_of(top_prio, grp_i)));

    assign pop  = done_i && !idle;
    assign push = ack_i && take_o && !done_i && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (pop) begin
            depth_q <= depth_q - 1'b1;
        end else if (push) begin
            stk[push_idx] <= win_prio_i;
            depth_q       <= depth_q + 1'b1;
        end
    end

    assign depth_o    = depth_q;
    assign act_prio_o = top_prio;

    // R10
    depth_cap_chk: assert property (@(posedge clk) disable iff (rst)
        depth_o <= DEPTH_W'(DEPTH));

    // R10
    push_level_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && take_o && !done_i && depth_o != DEPTH_W'(DEPTH))
        |=> (depth_o == $past(depth_o) + 1'b1) && (act_prio_o == $past(win_prio_i)));

    // R11
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && depth_o != '0) |=> (depth_o == $past(depth_o) - 1'b1));

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && depth_o == '0) |=> (depth_o == '0));

endmodule

// File: rtl/gpa_ctrl.sv
`timescale 1ns/1ps
module gpa_ctrl
    import gpa_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int DEPTH   = 16,
    parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [4:0]          wr_idx,
    input  logic [31:0]         wr_data,
    input  logic [LINES-1:0]    pend_i,
    input  logic                ack_i,
    input  logic                done_i,
    output logic                win_vld_o,
    output logic [4:0]          win_id_o,
    output logic                take_o,
    output logic [DEPTH_W-1:0]  depth_o,
    output logic [3:0]          act_prio_o
);

    logic [LINES-1:0]              en;
    logic [LINES-1:0][PRIO_W-1:0]  prio;
    logic [GRP_W-1:0]              grp;
    cand_t                         win;

    gpa_regs #(.LINES(LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .en_o    (en),
        .prio_o  (prio),
        .grp_o   (grp)
    );

    gpa_select #(.LINES(LINES)) u_select (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_i),
        .en_i   (en),
        .prio_i (prio),
        .win_o  (win)
    );

    gpa_nest #(.DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_nest (
        .clk        (clk),
        .rst        (rst),
        .win_vld_i  (win.vld),
        .win_prio_i (win.prio),
        .grp_i      (grp),
        .ack_i      (ack_i),
        .done_i     (done_i),
        .take_o     (take_o),
        .depth_o    (depth_o),
        .act_prio_o (act_prio_o)
    );

    assign win_vld_o = win.vld;
    assign win_id_o  = win.id;

    // R9
    flat_group_chk: assert property (@(posedge clk) disable iff (rst)
        (grp == '0 && depth_o != '0) |-> !take_o);

    // R7
    idle_take_chk: assert property (@(posedge clk) disable iff (rst)
        (depth_o == '0 && win_vld_o) |-> take_o);

endmodule

// File: tb/gpa_ctrl_test.sv
`timescale 1ns/1ps
module gpa_ctrl_test;

    localparam int LINES = 32;
    localparam int DEPTH = 16;
    localparam int DW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [4:0]    wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   pend = '0;
    logic          ack = 1'b0;
    logic          done = 1'b0;
    logic          win_vld_o;
    logic [4:0]    win_id_o;
    logic          take_o;
    logic [DW-1:0] depth_o;
    logic [3:0]    act_prio_o;

    int n_run = 0;
    int n_fail = 0;

    // reference model
    bit en_m [LINES];
    int prio_m [LINES];
    int grp_m;
    int stk_m [DEPTH];
    int dep_m;

    always #2.5 clk = ~clk;

    gpa_ctrl #(.LINES(LINES), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .pend_i(pend), .ack_i(ack), .done_i(done),
        .win_vld_o(win_vld_o), .win_id_o(win_id_o), .take_o(take_o),
        .depth_o(depth_o), .act_prio_o(act_prio_o)
    );

    function automatic int pre(int p);
        return p >> (4 - grp_m);
    endfunction

    function automatic void model(output bit v, output int id, output bit tk);
        int best = 99;
        v = 0; id = 0;
        for (int i = 0; i < LINES; i++)
            if (pend[i] && en_m[i] && prio_m[i] < best) begin
                best = prio_m[i]; id = i; v = 1;
            end
        tk = v && (dep_m == 0 || pre(prio_m[id]) < pre(stk_m[dep_m-1]));
    endfunction

    task automatic chk(string req, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        bit v, tk; int id;
        @(negedge clk); #0.5;
        model(v, id, tk);
        chk({req, " win_vld"}, int'(win_vld_o), int'(v));
        if (v) chk({req, " win_id"}, int'(win_id_o), id);
        chk({req, " take"}, int'(take_o), int'(tk));
        chk({req, " depth"}, int'(depth_o), dep_m);
        chk({req, " act_prio"}, int'(act_prio_o), dep_m > 0 ? stk_m[dep_m-1] : 0);
    endtask

    task automatic wr(int sel, int idx, logic [31:0] data);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'(sel); wr_idx = 5'(idx); wr_data = data;
        @(posedge clk); #0.5;
        wr_en = 0;
        case (sel)
            0: for (int i = 0; i < LINES; i++) if (data[i]) en_m[i] = 1;
            1: for (int i = 0; i < LINES; i++) if (data[i]) en_m[i] = 0;
            2: prio_m[idx] = int'(data[7:4]);
            default: if (data[31:16] == 16'h05FA)
                         grp_m = (data[10:8] > 4) ? 4 : int'(data[10:8]);
        endcase
    endtask

    task automatic set_pend(logic [31:0] p);
        @(negedge clk); pend = p;
    endtask

    task automatic do_ack();
        bit v, tk; int id;
        @(negedge clk); #0.5;
        model(v, id, tk);
        ack = 1;
        @(posedge clk); #0.5;
        ack = 0;
        if (tk && dep_m < DEPTH) begin stk_m[dep_m] = prio_m[id]; dep_m++; end
    endtask

    task automatic do_done();
        @(negedge clk);
        done = 1;
        @(posedge clk); #0.5;
        done = 0;
        if (dep_m > 0) dep_m--;
    endtask

    task automatic drain();
        while (dep_m > 0) do_done();
    endtask

    task automatic t_reset();
        set_pend('1);
        check_all("R1");
        chk("R1 no winner", int'(win_vld_o), 0);
        chk("R1 depth", int'(depth_o), 0);
    endtask

    task automatic t_enable();
        wr(0, 0, 32'h0000_0005);
        check_all("R2 set");
        chk("R2 winner line0", int'(win_id_o), 0);
        wr(1, 0, 32'h0000_0001);
        check_all("R2 clear");
        chk("R2 winner line2", int'(win_id_o), 2);
        wr(0, 0, 32'h0);
        wr(1, 0, 32'h0);
        check_all("R2 zero writes");
        chk("R2 still line2", int'(win_id_o), 2);
    endtask

    task automatic t_prio();
        wr(0, 0, 32'h0000_0001);
        wr(2, 0, 32'h0000_00F0);
        check_all("R3 urgency");
        chk("R3 line2 wins", int'(win_id_o), 2);
        wr(2, 2, 32'hFFFF_FF3A);
        wr(2, 0, 32'h0000_002F);
        check_all("R3 low nibble ignored");
        chk("R3 line0 wins", int'(win_id_o), 0);
    endtask

    task automatic t_order();
        wr(0, 0, 32'hFFFF_FFFF);
        for (int i = 0; i < LINES; i++) wr(2, i, 32'h80);
        set_pend(32'h0F00_0F00);
        check_all("R6 tie");
        chk("R6 lowest line on tie", int'(win_id_o), 8);
        wr(2, 27, 32'h70);
        check_all("R6 urgency first");
        chk("R6 line27", int'(win_id_o), 27);
    endtask

    task automatic t_disabled();
        wr(2, 5, 32'h00);
        wr(1, 0, 32'h0000_0020);
        set_pend(32'h0000_0120);
        check_all("R5 disabled");
        chk("R5 line8 not 5", int'(win_id_o), 8);
        wr(0, 0, 32'h0000_0020);
        check_all("R5 reenable");
        chk("R5 line5 wins", int'(win_id_o), 5);
    endtask

    task automatic t_key();
        // lines: 3 -> 0x3, 4 -> 0x2
        for (int i = 0; i < LINES; i++) wr(2, i, 32'hF0);
        wr(2, 3, 32'h30);
        wr(2, 4, 32'h20);
        wr(3, 0, 32'h05FB_0400);
        set_pend(32'h0000_0008);
        check_all("R7 idle take");
        chk("R7 take", int'(take_o), 1);
        do_ack();
        set_pend(32'h0000_0018);
        check_all("R4 bad key / R9 no nest");
        chk("R9 take 0", int'(take_o), 0);
        do_ack();
        check_all("R10 ack ignored");
        chk("R10 depth stays 1", int'(depth_o), 1);
        wr(3, 0, 32'h05FA_0700);
        check_all("R4 saturated to 4");
        chk("R8 sub-level nest", int'(take_o), 1);
        wr(3, 0, 32'h05FA_0300);
        check_all("R8 equal level waits");
        chk("R8 take 0", int'(take_o), 0);
        wr(3, 0, 32'h05FA_0400);
        do_ack();
        check_all("R10 pushed");
        chk("R10 act_prio", int'(act_prio_o), 2);
        do_done();
        check_all("R11 pop");
        chk("R11 back to 3", int'(act_prio_o), 3);
        do_done();
        do_done();
        check_all("R11 done at idle");
        chk("R11 depth 0", int'(depth_o), 0);
    endtask

    task automatic t_sweep();
        for (int g = 0; g <= 4; g++) begin
            wr(3, 0, 32'h05FA_0000 | (g << 8));
            for (int i = 0; i < LINES; i++) wr(2, i, ($urandom % 16) << 4);
            wr(0, 0, 32'hFFFF_FFFF);
            for (int it = 0; it < 40; it++) begin
                set_pend($urandom & $urandom);
                check_all(g == 0 ? "R9 sweep" : "R8 sweep");
                case ($urandom % 4)
                    0, 1: do_ack();
                    2: do_done();
                    default: ;
                endcase
                check_all("R10 R11 sweep");
            end
            drain();
        end
        set_pend('0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        grp_m = 0; dep_m = 0;
        for (int i = 0; i < LINES; i++) begin en_m[i] = 0; prio_m[i] = 0; end
        repeat (3) @(posedge clk);
        #0.5 rst = 0;
        t_reset();
        t_enable();
        t_prio();
        t_order();
        t_disabled();
        t_key();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule